// File: doc/BRIEF.md
# Windowed Question-Answer Watchdog

This block supervises a host processor from outside. It keeps an 8-bit pseudo-random challenge, and the host must answer it with the bitwise inverse of that challenge. The answer only counts if it arrives during the open half of a repeating refresh window. Each window is split into a closed part followed by an open part. A correct answer in the open part advances the challenge, raises the refresh count, lowers the error count by one and starts a new window. Any other outcome adds two to the error count and starts a new window. The other outcomes are a wrong value, an answer in the closed part, or silence until the window runs out. When the error count reaches its ceiling of 6, the block raises a reset request.

Time is counted in strobes of a 1 ms tick input. After reset the block is in a start-up phase. In that phase there is one open window of 256 ticks, and the host may choose the window length and load its own challenge seed. The start-up phase ends at the first correct answer. From then on, periodic refresh is required and the configuration is frozen.

Top module: `qa_watchdog`

## Requirements
- R1: After reset the challenge reads 0xA5, the error and refresh counts read 0, reset_req, refresh_ok and refresh_bad are low, and the block is in the start-up phase.
- R2: A window code selects the window length L in ticks: codes 0 to 3 give 1, 2, 3 and 4; codes 4 to 11 give 2^(code-1), that is 8 up to 1024; codes 12 to 15 give 3. The code after reset is 2 (3 ticks). The closed part lasts floor(L/2) ticks after a window start, and the rest of the window is open.
- R3: An answer given while the window is closed counts as a bad refresh, whatever its value.
- R4: If no answer comes, the tick that completes L ticks since the window start produces a bad refresh and starts a new window.
- R5: The start-up phase uses a window of 256 ticks that is open from its first cycle. A timeout in that phase is a bad refresh and restarts the same 256-tick window. Window code writes take effect only during the start-up phase.
- R6: A seed write loads the challenge only during the start-up phase and only when the seed is nonzero. Any other seed write leaves the challenge unchanged.
- R7: The correct answer is the bitwise inverse of the challenge. On each good refresh the challenge c becomes {c[6:0], c[7]^c[5]^c[4]^c[3]}.
- R8: A good refresh pulses refresh_ok for one cycle, raises the refresh count by 1 (modulo 256), lowers the error count by 1 with a floor of 0, restarts the window, and ends the start-up phase.
- R9: A bad refresh pulses refresh_bad for one cycle, raises the error count by 2 with a ceiling of 6, restarts the window, and leaves the challenge unchanged.
- R10: reset_req rises when the error count reaches 6 and stays high until rst_n is asserted, even if later good refreshes lower the count.
- R11: An answer that arrives in the same cycle as the expiring tick is judged as an answer, and no timeout is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_ms | input | 1 | One-cycle strobe per millisecond |
| cfg_win_we | input | 1 | Write strobe for the window code |
| cfg_win_code | input | 4 | Window code (see R2) |
| seed_we | input | 1 | Write strobe for the challenge seed |
| seed_val | input | 8 | Seed value |
| ans_valid | input | 1 | Answer strobe |
| ans_data | input | 8 | Answer value |
| challenge | output | 8 | Current challenge |
| err_count | output | 3 | Error count, 0 to 6 |
| refresh_count | output | 8 | Count of good refreshes |
| refresh_ok | output | 1 | One-cycle pulse on a good refresh |
| refresh_bad | output | 1 | One-cycle pulse on a bad refresh |
| reset_req | output | 1 | Sticky reset request |

## Verification
Each result is registered at the rising edge that samples the answer strobe or the expiring tick. The result pulse, the new counts and the new challenge are therefore visible one cycle after that stimulus and last exactly one cycle. The bench drives inputs on falling edges and predicts every pulse at the moment it drives the cause. A monitor compares the outputs on the next falling edge, the first point at which they are settled. Because every pulse must match a queued prediction at that edge, an early, late or missing timeout is caught in the exact cycle where it differs.

// File: rtl/qawd_pkg.sv
package qawd_pkg;

  localparam int unsigned MAX_WIN_MS = 1024;
  localparam int unsigned TMR_W      = $clog2(MAX_WIN_MS + 1);
  localparam int unsigned CHAL_W     = 8;

  typedef logic [TMR_W-1:0]  ms_t;
  typedef logic [CHAL_W-1:0] chal_t;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } ev_e;

  // Window code to length in ticks; unsupported codes fall back to 3.
  function automatic ms_t code_to_len(input logic [3:0] code);
    ms_t len;
    case (code)
      4'd0: len = ms_t'(1);
      4'd1: len = ms_t'(2);
      4'd2: len = ms_t'(3);
      4'd3: len = ms_t'(4);
      4'd4, 4'd5, 4'd6, 4'd7,
      4'd8, 4'd9, 4'd10, 4'd11: len = ms_t'(1) << (code - 4'd1);
      default: len = ms_t'(3);
    endcase
    return len;
  endfunction

  // Shift-left LFSR, taps for x^8+x^6+x^5+x^4+1.
  function automatic chal_t lfsr_step(input chal_t s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/qawd_timer.sv
module qawd_timer
  import qawd_pkg::*;
#(
  parameter int unsigned INIT_MS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic init_mode,
  input  ms_t  win_len,
  output logic is_open,
  output logic expire
);

  ms_t cnt_q, cnt_d;
  ms_t len_cur, closed_len;

  always_comb begin
    len_cur    = init_mode ? ms_t'(INIT_MS) : win_len;
    closed_len = init_mode ? '0 : (win_len >> 1);
    is_open    = (cnt_q >= closed_len);
    expire     = tick && (cnt_q == (len_cur - ms_t'(1)));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + ms_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/qawd_lfsr.sv
module qawd_lfsr
  import qawd_pkg::*;
#(
  parameter chal_t DEF_SEED = 8'hA5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  load,
  input  chal_t load_val,
  output chal_t state
);

  chal_t st_q, st_d;
  logic  st_en;

  always_comb begin
    st_en = advance || load;
    st_d  = advance ? lfsr_step(st_q) : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DEF_SEED;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/qawd_errcnt.sv
module qawd_errcnt #(
  parameter int unsigned ERR_MAX = 6,
  parameter int unsigned ERR_UP  = 2,
  parameter int unsigned ERR_DN  = 1,
  localparam int unsigned EW     = $clog2(ERR_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          good,
  input  logic          bad,
  output logic [EW-1:0] err,
  output logic          req
);

  localparam logic [EW-1:0] MAXV = EW'(ERR_MAX);
  localparam logic [EW-1:0] DNV  = EW'(ERR_DN);
  localparam logic [EW:0]   UPV  = (EW+1)'(ERR_UP);

  logic [EW-1:0] err_q, err_d;
  logic [EW:0]   up_sum;
  logic          req_q, req_d;

  always_comb begin
    up_sum = {1'b0, err_q} + UPV;
    err_d  = err_q;
    if (good) begin
      err_d = (err_q >= DNV) ? (err_q - DNV) : '0;
    end else if (bad) begin
      err_d = (up_sum >= {1'b0, MAXV}) ? MAXV : up_sum[EW-1:0];
    end
    req_d = req_q || (err_d == MAXV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      req_q <= 1'b0;
    end else begin
      err_q <= err_d;
      req_q <= req_d;
    end
  end

  assign err = err_q;
  assign req = req_q;

endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
  import qawd_pkg::*;
#(
  parameter int unsigned INIT_MS  = 256,
  parameter logic [3:0]  DEF_CODE = 4'd2,
  parameter logic [7:0]  DEF_SEED = 8'hA5,
  parameter int unsigned REF_W    = 8,
  parameter int unsigned ERR_MAX  = 6,
  parameter int unsigned ERR_UP   = 2,
  parameter int unsigned ERR_DN   = 1,
  localparam int unsigned EW      = $clog2(ERR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             cfg_win_we,
  input  logic [3:0]       cfg_win_code,
  input  logic             seed_we,
  input  logic [7:0]       seed_val,
  input  logic             ans_valid,
  input  logic [7:0]       ans_data,
  output logic [7:0]       challenge,
  output logic [EW-1:0]    err_count,
  output logic [REF_W-1:0] refresh_count,
  output logic             refresh_ok,
  output logic             refresh_bad,
  output logic             reset_req
);

  logic             init_q, init_d;
  logic [3:0]       code_q;
  logic             code_en;
  ms_t              win_len;
  logic             is_open, expire;
  logic             ans_good, ev_good, ev_bad, restart, seed_load;
  ev_e              ev_q, ev_d;
  logic [REF_W-1:0] ref_q, ref_d;
  chal_t            chal;

  // Next-state logic
  always_comb begin
    win_len   = code_to_len(code_q);
    ans_good  = ans_valid && is_open && (ans_data == ~chal);
    ev_good   = ans_good;
    ev_bad    = (ans_valid && !ans_good) || (!ans_valid && expire);
    restart   = ans_valid || expire;
    init_d    = init_q && !ev_good;
    code_en   = cfg_win_we && init_q;
    seed_load = seed_we && init_q && (seed_val != '0) && !ev_good;
    ref_d     = ev_good ? (ref_q + REF_W'(1)) : ref_q;
    ev_d      = ev_good ? EV_GOOD : (ev_bad ? EV_BAD : EV_NONE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      code_q <= DEF_CODE;
      ev_q   <= EV_NONE;
      ref_q  <= '0;
    end else begin
      init_q <= init_d;
      if (code_en) begin
        code_q <= cfg_win_code;
      end
      ev_q  <= ev_d;
      ref_q <= ref_d;
    end
  end

  qawd_timer #(
    .INIT_MS (INIT_MS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_ms),
    .restart   (restart),
    .init_mode (init_q),
    .win_len   (win_len),
    .is_open   (is_open),
    .expire    (expire)
  );

  qawd_lfsr #(
    .DEF_SEED (DEF_SEED)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (ev_good),
    .load     (seed_load),
    .load_val (seed_val),
    .state    (chal)
  );

  qawd_errcnt #(
    .ERR_MAX (ERR_MAX),
    .ERR_UP  (ERR_UP),
    .ERR_DN  (ERR_DN)
  ) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .good  (ev_good),
    .bad   (ev_bad),
    .err   (err_count),
    .req   (reset_req)
  );

  assign challenge     = chal;
  assign refresh_count = ref_q;
  assign refresh_ok    = (ev_q == EV_GOOD);
  assign refresh_bad   = (ev_q == EV_BAD);

endmodule

// File: rtl/qa_watchdog_chk.sv
module qa_watchdog_chk
  import qawd_pkg::*;
#(
  parameter int unsigned ERR_MAX = 6,
  parameter int unsigned REF_W   = 8,
  localparam int unsigned EW     = $clog2(ERR_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_we,
  input logic [7:0]       challenge,
  input logic [EW-1:0]    err_count,
  input logic [REF_W-1:0] refresh_count,
  input logic             refresh_ok,
  input logic             refresh_bad,
  input logic             reset_req
);

  p_err_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(err_count) <= ERR_MAX);

  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_ok && refresh_bad));

  p_good_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |-> int'(err_count) ==
      ((int'($past(err_count)) > 0) ? int'($past(err_count)) - 1 : 0));

  p_good_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |-> refresh_count == $past(refresh_count) + REF_W'(1));

  p_good_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |-> challenge == lfsr_step($past(challenge)));

  p_bad_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_bad |-> int'(err_count) ==
      ((int'($past(err_count)) + 2 >= int'(ERR_MAX)) ? int'(ERR_MAX) : int'($past(err_count)) + 2));

  p_bad_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_bad && !$past(seed_we)) |-> $stable(challenge));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> int'(err_count) == ERR_MAX);

endmodule

bind qa_watchdog qa_watchdog_chk #(
  .ERR_MAX (ERR_MAX),
  .REF_W   (REF_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .seed_we       (seed_we),
  .challenge     (challenge),
  .err_count     (err_count),
  .refresh_count (refresh_count),
  .refresh_ok    (refresh_ok),
  .refresh_bad   (refresh_bad),
  .reset_req     (reset_req)
);

// File: tb/tb_qa_watchdog.sv
module tb_qa_watchdog;

  logic       clk;
  logic       rst_n;
  logic       tick_ms;
  logic       cfg_win_we;
  logic [3:0] cfg_win_code;
  logic       seed_we;
  logic [7:0] seed_val;
  logic       ans_valid;
  logic [7:0] ans_data;
  logic [7:0] challenge;
  logic [2:0] err_count;
  logic [7:0] refresh_count;
  logic       refresh_ok;
  logic       refresh_bad;
  logic       reset_req;

  qa_watchdog dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_ms       (tick_ms),
    .cfg_win_we    (cfg_win_we),
    .cfg_win_code  (cfg_win_code),
    .seed_we       (seed_we),
    .seed_val      (seed_val),
    .ans_valid     (ans_valid),
    .ans_data      (ans_data),
    .challenge     (challenge),
    .err_count     (err_count),
    .refresh_count (refresh_count),
    .refresh_ok    (refresh_ok),
    .refresh_bad   (refresh_bad),
    .reset_req     (reset_req)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  typedef struct {
    bit ok;
    bit bad;
    int err;
    int chal;
    int refc;
    bit req;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  exp_t  mon_e;
  string mon_t;

  // Reference model state
  logic [7:0] m_chal;
  int m_err, m_ref, m_pos, m_len;
  bit m_req, m_init;

  function automatic logic [7:0] nxt(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic int len_of(input int c);
    if (c <= 3) return c + 1;
    if (c <= 11) return 1 << (c - 1);
    return 3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic predict(input bit good, input string tag);
    exp_t e;
    if (good) begin
      m_chal = nxt(m_chal);
      m_ref  = (m_ref + 1) % 256;
      m_err  = (m_err > 0) ? m_err - 1 : 0;
      m_init = 0;
    end else begin
      m_err = (m_err + 2 > 6) ? 6 : m_err + 2;
    end
    if (m_err == 6) m_req = 1;
    m_pos = 0;
    e.ok = good; e.bad = !good; e.err = m_err;
    e.chal = int'(m_chal); e.refc = m_ref; e.req = m_req;
    sb_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: every result pulse must match the oldest prediction
  always @(negedge clk) begin
    if (rst_n && (refresh_ok || refresh_bad)) begin
      if (sb_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R4: unexpected event actual ok=%0b bad=%0b expected none",
                 refresh_ok, refresh_bad);
      end else begin
        mon_e = sb_q.pop_front();
        mon_t = tag_q.pop_front();
        chk({mon_t, " ok"},   int'(refresh_ok),    int'(mon_e.ok));
        chk({mon_t, " bad"},  int'(refresh_bad),   int'(mon_e.bad));
        chk({mon_t, " err"},  int'(err_count),     mon_e.err);
        chk({mon_t, " chal"}, int'(challenge),     mon_e.chal);
        chk({mon_t, " ref"},  int'(refresh_count), mon_e.refc);
        chk({mon_t, " req"},  int'(reset_req),     int'(mon_e.req));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sb_q.delete();
    tag_q.delete();
    m_chal = 8'hA5; m_err = 0; m_ref = 0; m_pos = 0;
    m_len = 3; m_req = 0; m_init = 1;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick(input string tag);
    int len;
    len = m_init ? 256 : m_len;
    tick_ms = 1'b1;
    if (m_pos == len - 1) predict(0, tag);
    else m_pos++;
    @(negedge clk);
    tick_ms = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) do_tick(tag);
  endtask

  task automatic do_answer(input logic [7:0] data, input bit with_tick, input string tag);
    int closed;
    closed = m_init ? 0 : m_len / 2;
    ans_valid = 1'b1;
    ans_data  = data;
    tick_ms   = with_tick;
    predict((m_pos >= closed) && (data == ~m_chal), tag);
    @(negedge clk);
    ans_valid = 1'b0;
    tick_ms   = 1'b0;
    @(negedge clk);
  endtask

  task automatic good_ans(input string tag);
    do_answer(~m_chal, 0, tag);
  endtask

  task automatic write_code(input logic [3:0] c);
    cfg_win_we   = 1'b1;
    cfg_win_code = c;
    if (m_init) m_len = len_of(int'(c));
    @(negedge clk);
    cfg_win_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_seed(input logic [7:0] v, input string tag);
    seed_we  = 1'b1;
    seed_val = v;
    if (m_init && v != 8'h00) m_chal = v;
    @(negedge clk);
    seed_we = 1'b0;
    chk(tag, int'(challenge), int'(m_chal));
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick_ms = 1'b0; cfg_win_we = 1'b0; cfg_win_code = '0;
    seed_we = 1'b0; seed_val = '0; ans_valid = 1'b0; ans_data = '0;
    do_reset();

    // R1: reset state
    chk("R1 challenge", int'(challenge), 8'hA5);
    chk("R1 err", int'(err_count), 0);
    chk("R1 ref", int'(refresh_count), 0);
    chk("R1 req", int'(reset_req), 0);
    chk("R1 ok", int'(refresh_ok), 0);
    chk("R1 bad", int'(refresh_bad), 0);

    // R6: zero seed ignored, nonzero seed loaded during start-up
    write_seed(8'h00, "R6 zero seed");
    write_seed(8'h3C, "R6 seed load");
    write_code(4'd3);                      // 4-tick window
    good_ans("R5 start-up answer at once");

    // R6 / R5: configuration frozen after start-up
    write_seed(8'h77, "R6 seed after start-up");
    write_code(4'd0);                      // must be ignored, 4 ticks stays
    do_tick("R5 code frozen");
    do_answer(~m_chal, 0, "R3 answer in closed part");
    ticks(2, "R8");
    good_ans("R8 good in open part");
    ticks(4, "R4 timeout on 4th tick");
    ticks(3, "R11");
    do_answer(~m_chal, 1, "R11 answer with expiring tick");
    ticks(2, "R9");
    do_answer(~m_chal ^ 8'h01, 0, "R9 wrong value");
    chk("R9 challenge kept", int'(challenge), int'(m_chal));
    for (int i = 0; i < 5; i++) begin
      ticks(2, "R8");
      good_ans("R8 error floor");
    end
    chk("R8 err floor", int'(err_count), 0);
    for (int i = 0; i < 3; i++) begin
      ticks(2, "R10");
      do_answer(~m_chal ^ 8'h80, 0, "R10 wrong value");
    end
    chk("R10 req raised", int'(reset_req), 1);
    ticks(2, "R10");
    good_ans("R10 good after request");
    chk("R10 req held", int'(reset_req), 1);

    // R2: default 3-tick window, closed 1 tick
    do_reset();
    good_ans("R7 first answer");
    do_answer(~m_chal, 0, "R2 default closed part");
    do_tick("R2");
    good_ans("R2 default open part");
    ticks(3, "R2 default timeout");

    // R2: unsupported code maps to 3 ticks
    do_reset();
    write_code(4'd13);
    good_ans("R2 start");
    ticks(3, "R2 unsupported code timeout");

    // R2: code 0, one-tick window, open at once
    do_reset();
    write_code(4'd0);
    good_ans("R2 start");
    ticks(1, "R2 1-tick timeout");
    good_ans("R2 1-tick open at once");

    // R2: code 11, 1024-tick window
    do_reset();
    write_code(4'd11);
    good_ans("R2 start");
    ticks(511, "R2");
    do_answer(~m_chal, 0, "R2 1024 still closed at 511");
    ticks(512, "R2");
    good_ans("R2 1024 open at 512");
    ticks(1024, "R2 1024 timeout");

    // R5: start-up timeout after 256 ticks, start-up window reopens
    do_reset();
    ticks(256, "R5 start-up timeout");
    good_ans("R5 start-up answer after timeout");

    repeat (3) @(negedge clk);
    chk("R4 all predicted events seen", sb_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule